// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave serial port that lets a host read and write a small window of eight 8-bit registers located at addresses 10h to 17h. The host frames every access with an active-low select. Each access begins with an 8-bit command byte. Data bytes follow at once, and every byte travels least significant bit first. The command carries a read/write flag in its first bit and a 6-bit register address in the next six bits. Its last bit is a burst flag. When the burst flag is set, the address field is ignored and the port walks the whole window from 10h up to 17h, then stops.

The port runs on a fast system clock and oversamples the select, serial clock, data and edge-select pins through synchronizers. It acts on the edges of the serial clock it detects there. Incoming bits are taken on rising serial-clock edges. An edge-select input chooses whether outgoing read data changes after the falling edge (select = 1) or after the rising edge (select = 0). The output driver is controlled by a separate enable, so the output can be tri-stated outside a read. The register store is a plain read-back memory that resets to zero.

Top module: `ser_reg_port`

## Requirements
- R1: Command byte layout: bit 0 (first shifted) = 1 for read, 0 for write; bits 6:1 = register address, bit 1 least significant; bit 7 = burst flag.
- R2: A non-burst write with an address in 10h..17h stores the following data byte, received LSb first, into that register.
- R3: A non-burst read drives the addressed register's byte LSb first on sdo with sdo_oe high; bit k is valid just before rising serial-clock edge 9+k, and sdo_oe falls after the byte.
- R4: With edge_sel = 1, sdo changes only after falling serial-clock edges, so it holds its value across the rising edge. With edge_sel = 0, sdo changes after rising edges.
- R5: sdo_oe is low while cs_n is high and throughout any write transfer.
- R6: A burst write stores consecutive data bytes into 10h, 11h, … 17h in that order, whatever the address field holds. Bytes beyond the eighth are dropped.
- R7: A burst read returns the bytes of 10h through 17h in order. After the byte of 17h, sdo_oe goes low for the rest of the transfer.
- R8: cs_n going high aborts the transfer and clears the port state. The next low period starts again with a command byte.
- R9: A write takes effect only when all 8 bits of a data byte have arrived. A byte cut short by cs_n leaves the register unchanged.
- R10: Addresses outside 10h..17h read back as zero, and writes to them change no register.
- R11: After reset every register reads zero and sdo_oe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts and idles the port |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, taken on rising sclk |
| edge_sel | input | 1 | 1: sdo changes after falling sclk; 0: after rising sclk |
| sdo | output | 1 | Serial read data, LSb first |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |

## Verification
The position counter addresses every byte and every bit. If it slips, the read data comes out rotated, or bytes appear at the wrong burst address, on the very next readback. A stale command register would show as sdo_oe rising during a write, or failing to drop within a few system clocks of cs_n going high. Write-strobe faults surface only when the affected register is read back later. For that reason the bench reads back after every write, after burst writes, after truncated bytes and after writes outside the window.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int CMD_W    = ADDR_W + 2;
  localparam logic [ADDR_W-1:0] WIN_BASE = 6'h10;

  // bit 0 = read flag (first on the wire), MSb = burst flag
  typedef struct packed {
    logic              burst;
    logic [ADDR_W-1:0] addr;
    logic              rd;
  } cmd_t;

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    logic [ADDR_W:0] top;
    top = {1'b0, WIN_BASE} + (ADDR_W+1)'(NUM_REGS);
    return (a >= WIN_BASE) && ({1'b0, a} < top);
  endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int             W      = 4,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_rest
      assign stg_d = stg[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg_d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
  import srp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int IW = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [ADDR_W-1:0] woff, roff;

  assign woff = waddr - WIN_BASE;
  assign roff = raddr - WIN_BASE;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = we && (woff[IW-1:0] == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[g] <= '0;
      else if (hit) regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (in_window(raddr)) rdata = regs[roff[IW-1:0]];
  end

  // R10
  we_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> in_window(waddr));
endmodule

// File: rtl/srp_engine.sv
module srp_engine
  import srp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              edge_sel_s,
  output logic [ADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0] rdata,
  output logic              wr_en,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int BW = $clog2(DATA_W);
  localparam int CB = $clog2(CMD_W);
  localparam int CW = $clog2(CMD_W + NUM_REGS*DATA_W + 2);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CMD_LEN = CW'(CMD_W);

  // state registers
  logic              sclk_q;
  logic [CW-1:0]     cnt, cnt_d;
  cmd_t              cmd, cmd_d;
  logic [DATA_W-1:0] wsh, wsh_d;
  logic              sdo_r, sdo_d;
  logic              oe_r, oe_d;

  // edge events and decode
  logic              rise, fall, upd;
  logic [CW-1:0]     cnt_nxt, opos;
  cmd_t              cmd_nxt;
  logic              o_hit, i_hit;
  logic [ADDR_W-1:0] o_addr, i_addr;
  logic [BW-1:0]     o_bit, i_bit;

  // {hit, address, bit index} for a stream position
  function automatic logic [ADDR_W+BW:0] locate(input logic [CW-1:0] pos, input cmd_t c);
    logic [CW-1:0]     d;
    logic [CW-1:0]     blk;
    logic              hit;
    logic [ADDR_W-1:0] a;
    d   = pos - CMD_LEN;
    blk = d >> BW;
    if (pos < CMD_LEN) begin
      hit = 1'b0;
      a   = c.addr;
    end else if (c.burst) begin
      hit = blk < CW'(NUM_REGS);
      a   = WIN_BASE + ADDR_W'(blk);
    end else begin
      hit = (blk == '0);
      a   = c.addr;
    end
    return {hit, a, d[BW-1:0]};
  endfunction

  always_comb begin
    rise = ~cs_s &  sclk_s & ~sclk_q;
    fall = ~cs_s & ~sclk_s &  sclk_q;
    upd  = edge_sel_s ? fall : rise;

    cmd_nxt = cmd;
    if (rise && (cnt < CMD_LEN)) cmd_nxt[cnt[CB-1:0]] = sdi_s;
    cnt_nxt = (rise && (cnt != CNT_MAX)) ? cnt + 1'b1 : cnt;

    opos = edge_sel_s ? cnt : cnt_nxt;
    {o_hit, o_addr, o_bit} = locate(opos, cmd_nxt);
    {i_hit, i_addr, i_bit} = locate(cnt, cmd);
  end

  assign raddr = o_addr;
  assign waddr = i_addr;
  assign wdata = {sdi_s, wsh[DATA_W-1:1]};
  assign wr_en = rise & ~cmd.rd & i_hit & (i_bit == BW'(DATA_W-1)) & in_window(i_addr);

  // next state
  always_comb begin
    cnt_d = cnt_nxt;
    cmd_d = cmd_nxt;
    wsh_d = wsh;
    sdo_d = sdo_r;
    oe_d  = oe_r;
    if (rise && (cnt >= CMD_LEN)) wsh_d = {sdi_s, wsh[DATA_W-1:1]};
    if (cs_s) begin
      cnt_d = '0;
      cmd_d = '0;
      oe_d  = 1'b0;
    end else if (upd) begin
      sdo_d = (cmd_nxt.rd & o_hit) ? rdata[o_bit] : 1'b0;
      oe_d  = cmd_nxt.rd & o_hit;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt    <= '0;
      cmd    <= '0;
      wsh    <= '0;
      sdo_r  <= 1'b0;
      oe_r   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      cnt    <= cnt_d;
      cmd    <= cmd_d;
      wsh    <= wsh_d;
      sdo_r  <= sdo_d;
      oe_r   <= oe_d;
    end
  end

  assign sdo    = sdo_r;
  assign sdo_oe = oe_r;

  // R5
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !oe_r);

  // R5
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && (cnt >= CMD_LEN) && !cmd.rd) |=> !oe_r);

  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(sdo_r));

  // R9
  wr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (rise && (cnt >= CMD_LEN)));
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import srp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  input  logic edge_sel,
  output logic sdo,
  output logic sdo_oe
);
  localparam int SYNC_STAGES = 2;

  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  logic [3:0]        pins_s;
  logic [ADDR_W-1:0] raddr, waddr;
  logic [DATA_W-1:0] rdata, wdata;
  logic              wr_en;

  srp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d     ({cs_n, sclk, sdi, edge_sel}),
    .q     (pins_s)
  );

  srp_engine u_engine (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .cs_s       (pins_s[3]),
    .sclk_s     (pins_s[2]),
    .sdi_s      (pins_s[1]),
    .edge_sel_s (pins_s[0]),
    .raddr      (raddr),
    .rdata      (rdata),
    .wr_en      (wr_en),
    .waddr      (waddr),
    .wdata      (wdata),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe)
  );

  srp_regfile u_regs (
    .clk   (clk),
    .rst_n (core_rst_n),
    .we    (wr_en),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );
endmodule

// File: tb/tb_ser_reg_port.sv
module tb_ser_reg_port;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi, edge_sel;
  logic sdo, sdo_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] mem [8];
  logic       post_oe;

  always #4 clk = ~clk;

  ser_reg_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .edge_sel(edge_sel), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_cmd(input logic rd, input logic [5:0] a, input logic burst);
    return {burst, a, rd};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [5:0] a);
    if (a >= 6'h10 && a <= 6'h17) return mem[a[2:0]];
    return 8'h00;
  endfunction

  // One framed transfer: command byte then ndata bits of data.
  task automatic xfer(input logic [7:0] cmd, input int ndata, input logic [79:0] wd,
                      input logic es, input int valid_bits,
                      output logic [79:0] rd, output logic oe_any,
                      output logic oe_all, output logic oe_tail, output logic mid8);
    logic [87:0] tx;
    tx = {wd, cmd};
    rd = '0; oe_any = 1'b0; oe_all = 1'b1; oe_tail = 1'b0; mid8 = 1'b0;
    edge_sel = es;
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < 8 + ndata; i++) begin
      sdi = tx[i];
      repeat (HALF) @(negedge clk);
      oe_any |= sdo_oe;
      if (i >= 8) begin
        rd[i-8] = sdo;
        if (i < 8 + valid_bits) oe_all &= sdo_oe;
        else                    oe_tail |= sdo_oe;
      end
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      oe_any |= sdo_oe;
      if (i == 8) mid8 = sdo;
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    post_oe = sdo_oe;
  endtask

  task automatic wr1(input logic [5:0] a, input logic [7:0] d, input logic es);
    logic [79:0] rd; logic oa, ol, ot, m;
    xfer(mk_cmd(1'b0, a, 1'b0), 8, {72'h0, d}, es, 8, rd, oa, ol, ot, m);
    check(!oa && !post_oe, "R5", "sdo_oe during single write", {62'h0, oa, post_oe}, 64'h0);
    if (a >= 6'h10 && a <= 6'h17) mem[a[2:0]] = d;
  endtask

  task automatic rd1(input logic [5:0] a, input logic es, input string req);
    logic [79:0] rd; logic oa, ol, ot, m;
    xfer(mk_cmd(1'b1, a, 1'b0), 16, '0, es, 8, rd, oa, ol, ot, m);
    check(rd[7:0] == exp_rd(a), req, "single read data", {56'h0, rd[7:0]}, {56'h0, exp_rd(a)});
    check(ol && !ot, "R3", "sdo_oe window of single read", {62'h0, ol, ot}, 64'h2);
  endtask

  task automatic burst_rd(input logic es, input string req);
    logic [79:0] rd; logic oa, ol, ot, m;
    logic [63:0] e;
    for (int k = 0; k < 8; k++) e[k*8 +: 8] = mem[k];
    xfer(mk_cmd(1'b1, 6'($urandom), 1'b1), 72, '0, es, 64, rd, oa, ol, ot, m);
    check(rd[63:0] == e, req, "burst read data", rd[63:0], e);
    check(ol, "R7", "sdo_oe high over burst bytes", {63'h0, ol}, 64'h1);
    check(!ot, "R7", "sdo_oe low after byte of 17h", {63'h0, ot}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [79:0] rd; logic oa, ol, ot, m;
    logic [63:0] bd;
    void'($urandom(32'd4711));
    for (int k = 0; k < 8; k++) mem[k] = 8'h00;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; edge_sel = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R11 reset state
    check(sdo_oe == 1'b0, "R11", "sdo_oe after reset", {63'h0, sdo_oe}, 64'h0);
    burst_rd(1'b0, "R11");

    // R1 R2 R3 random single writes and reads
    for (int n = 0; n < 8; n++) begin
      logic [5:0] a;
      logic [7:0] d;
      a = 6'h10 + 6'($urandom_range(0, 7));
      d = 8'($urandom);
      wr1(a, d, 1'($urandom));
      rd1(a, 1'($urandom), "R2");
    end
    rd1(6'h15, 1'b1, "R1");

    // R4 output edge: byte A5h, D0=1 D1=0
    wr1(6'h12, 8'hA5, 1'b0);
    xfer(mk_cmd(1'b1, 6'h12, 1'b0), 16, '0, 1'b1, 8, rd, oa, ol, ot, m);
    check(m == 1'b1, "R4", "edge_sel=1 sdo held over rising edge", {63'h0, m}, 64'h1);
    check(rd[7:0] == 8'hA5, "R4", "edge_sel=1 data", {56'h0, rd[7:0]}, 64'hA5);
    xfer(mk_cmd(1'b1, 6'h12, 1'b0), 16, '0, 1'b0, 8, rd, oa, ol, ot, m);
    check(m == 1'b0, "R4", "edge_sel=0 sdo moved after rising edge", {63'h0, m}, 64'h0);
    check(rd[7:0] == 8'hA5, "R4", "edge_sel=0 data", {56'h0, rd[7:0]}, 64'hA5);

    // R6 burst write with arbitrary address field, then R7 burst reads
    for (int r = 0; r < 2; r++) begin
      bd = {$urandom, $urandom};
      xfer(mk_cmd(1'b0, 6'($urandom), 1'b1), 80, {16'hFFFF, bd}, 1'($urandom), 64, rd, oa, ol, ot, m);
      check(!oa, "R5", "sdo_oe during burst write", {63'h0, oa}, 64'h0);
      for (int k = 0; k < 8; k++) mem[k] = bd[k*8 +: 8];
      burst_rd(1'b0, "R6");
      burst_rd(1'b1, "R7");
    end

    // R10 outside the window
    wr1(6'h05, 8'hFF, 1'b0);
    wr1(6'h18, 8'h3C, 1'b1);
    wr1(6'h3F, 8'h81, 1'b0);
    rd1(6'h05, 1'b0, "R10");
    rd1(6'h18, 1'b1, "R10");
    rd1(6'h3F, 1'b1, "R10");
    burst_rd(1'b1, "R10");

    // R9 truncated data byte
    xfer(mk_cmd(1'b0, 6'h13, 1'b0), 5, {72'h0, ~mem[3]}, 1'b0, 5, rd, oa, ol, ot, m);
    rd1(6'h13, 1'b0, "R9");

    // R8 abort in the middle of a read
    xfer(mk_cmd(1'b1, 6'h14, 1'b0), 4, '0, 1'b1, 4, rd, oa, ol, ot, m);
    check(ol, "R8", "sdo_oe before abort", {63'h0, ol}, 64'h1);
    check(rd[3:0] == mem[4][3:0], "R8", "partial read bits", {60'h0, rd[3:0]}, {60'h0, mem[4][3:0]});
    check(!post_oe, "R5", "sdo_oe after cs_n high", {63'h0, post_oe}, 64'h0);
    // abort inside the command byte, then a fresh write
    xfer(8'h01, -5, '0, 1'b0, 0, rd, oa, ol, ot, m);
    wr1(6'h14, 8'h5A, 1'b1);
    rd1(6'h14, 1'b0, "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule